// File: doc/BRIEF.md
# Processor-to-ISA I/O Address Translator

This block sits between a processor load/store port and an ISA-style I/O port engine. It claims processor accesses that fall in an 8 MB I/O window based at 0x80000000. Each claimed access becomes one port cycle on the ISA side, with a 16-bit port address, a transfer size, write data and a read or write strobe. The strobe is held until the ISA side acknowledges. Accesses outside the window are left alone.

The port address comes from one of two maps, chosen by a map-select input. The flat map keeps the low 16 address bits. The sparse map keeps address bits 4..0 and moves bits 22..12 down to port bits 15..5, so address bits 11..5 are dropped. When the processor runs big-endian, data lanes are reordered by transfer size. A halfword swaps its two bytes. A word has all four bytes reversed. A byte is never touched. The same reordering is applied to write data going out and to read data coming back.

The map select and the endian select are captured when a request is accepted and held for the whole access. Only one access is outstanding at a time. The completion is reported one cycle after the acknowledge, and read data is delivered in a register at that point.

Top module: `isa_io_xlate`

## Requirements
- R1: A request is accepted only when `cpu_addr[31:23]` equals 9'h100 (window 0x80000000..0x807FFFFF). A request outside the window raises no ISA strobe, produces no completion, and leaves `cpu_ready` high.
- R2: With `map_sparse`=0 at acceptance, `isa_port` equals `cpu_addr[15:0]`.
- R3: With `map_sparse`=1 at acceptance, `isa_port` equals {`cpu_addr[22:12]`, `cpu_addr[4:0]`}. Address bits 11..5 have no effect.
- R4: `map_sparse` and `big_endian` are sampled in the acceptance cycle. Changing them while an access is outstanding does not alter `isa_port`, `isa_wdata` or the returned read data.
- R5: Size code 0 (byte) passes data unchanged in both directions, whatever `big_endian` is.
- R6: With `big_endian`=1, size code 1 (halfword) swaps bits 7..0 with bits 15..8. Bits 31..16 pass unchanged. This applies to write data and to read data.
- R7: With `big_endian`=1, size code 2 (word) and reserved code 3 reverse all four bytes, in both directions.
- R8: With `big_endian`=0, no lane is reordered for any size.
- R9: One clock after acceptance, exactly one of `isa_rd` (read) or `isa_wr` (write) is high. It stays high until the edge on which `isa_ack` is seen. `isa_port` and `isa_size` (a copy of the size code) are held stable for the whole access.
- R10: The clock after the acknowledge, the strobe is low and `cpu_done` pulses for one cycle. For a read, `cpu_rvalid` pulses in the same cycle and `cpu_rdata` holds the reordered `isa_rdata`.
- R11: `cpu_ready` is low from acceptance until completion. Requests presented while it is low are ignored.
- R12: After reset, both strobes are low, `cpu_ready` is high, and `cpu_done` and `cpu_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 treated as word |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | High when a request can be accepted |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rvalid | output | 1 | One-cycle read data valid pulse |
| cpu_rdata | output | 32 | Registered, reordered read data |
| map_sparse | input | 1 | Address map select: 0 flat, 1 sparse |
| big_endian | input | 1 | Enables lane reordering |
| isa_port | output | 16 | ISA port address |
| isa_size | output | 2 | Transfer size code |
| isa_wdata | output | 32 | Reordered write data |
| isa_rd | output | 1 | ISA read strobe |
| isa_wr | output | 1 | ISA write strobe |
| isa_ack | input | 1 | ISA acknowledge |
| isa_rdata | input | 32 | ISA read data, taken on acknowledge |

## Verification
Two events can meet in a single cycle. The completion pulse of one access can be present while the next request is already waiting on the processor side. The bench checks that the waiting request is taken on the edge that ends the pulse, so that `cpu_done` falls and the new strobe rises together with the new port address. In a second case, requests are held during an outstanding access, and the map and endian selects are flipped at the same time. The bench then checks that the access finishes with the address and data lanes that were captured at acceptance, and that no extra strobe follows.

// File: rtl/isa_xlate_pkg.sv
`timescale 1ns/1ps
package isa_xlate_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } xfer_size_e;
endpackage

// File: rtl/isa_addr_remap.sv
`timescale 1ns/1ps
module isa_addr_remap #(
   parameter int ADDR_W     = 32,
   parameter int PORT_W     = 16,
   parameter int WIN_BITS   = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
   parameter int SPARSE_KEEP = 5,
   parameter int SPARSE_FROM = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sparse,
   output logic              hit,
   output logic [PORT_W-1:0] port
);
   localparam int HI_W = WIN_BITS - SPARSE_FROM;

   if (HI_W + SPARSE_KEEP != PORT_W) begin : g_bad_sparse
      $error("sparse fields must fill the port width exactly");
   end
   if (PORT_W > WIN_BITS || WIN_BITS >= ADDR_W) begin : g_bad_window
      $error("window and port widths inconsistent");
   end

   logic [PORT_W-1:0] flat_port;
   logic [PORT_W-1:0] sparse_port;

   assign hit         = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
   assign flat_port   = addr[PORT_W-1:0];
   assign sparse_port = {addr[WIN_BITS-1:SPARSE_FROM], addr[SPARSE_KEEP-1:0]};
   assign port        = sparse ? sparse_port : flat_port;
endmodule

// File: rtl/isa_lane_swap.sv
`timescale 1ns/1ps
module isa_lane_swap
   import isa_xlate_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        size,
   input  logic              be,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0 || LANES < 2) begin : g_bad_width
      $error("data width must be a multiple of 8 and at least 16");
   end

   if (SWAP_EN) begin : g_swap
      logic [DATA_W-1:0] rev;
      logic [DATA_W-1:0] hsw;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign rev[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
         if (i < 2) begin : g_low
            assign hsw[i*8 +: 8] = din[(1-i)*8 +: 8];
         end else begin : g_pass
            assign hsw[i*8 +: 8] = din[i*8 +: 8];
         end
      end
      always_comb begin
         if (!be) begin
            dout = din;
         end else begin
            case (xfer_size_e'(size))
               SZ_BYTE: dout = din;
               SZ_HALF: dout = hsw;
               default: dout = rev;
            endcase
         end
      end
   end else begin : g_noswap
      assign dout = din;
   end
endmodule

// File: rtl/isa_xlate_ctrl.sv
`timescale 1ns/1ps
module isa_xlate_ctrl #(
   parameter int PORT_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_we,
   input  logic [1:0]        start_size,
   input  logic [PORT_W-1:0] start_port,
   input  logic [DATA_W-1:0] start_wdata,
   input  logic              start_be,
   input  logic              isa_ack,
   input  logic [DATA_W-1:0] rd_swapped,
   output logic              busy,
   output logic              be_q,
   output logic              isa_rd,
   output logic              isa_wr,
   output logic [PORT_W-1:0] isa_port,
   output logic [1:0]        isa_size,
   output logic [DATA_W-1:0] isa_wdata,
   output logic              cpu_done,
   output logic              cpu_rvalid,
   output logic [DATA_W-1:0] cpu_rdata
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         be_q       <= 1'b0;
         isa_rd     <= 1'b0;
         isa_wr     <= 1'b0;
         isa_port   <= '0;
         isa_size   <= '0;
         isa_wdata  <= '0;
         cpu_done   <= 1'b0;
         cpu_rvalid <= 1'b0;
         cpu_rdata  <= '0;
      end else begin
         cpu_done   <= 1'b0;
         cpu_rvalid <= 1'b0;
         if (!busy && start) begin
            busy      <= 1'b1;
            isa_rd    <= !start_we;
            isa_wr    <= start_we;
            isa_port  <= start_port;
            isa_size  <= start_size;
            isa_wdata <= start_wdata;
            be_q      <= start_be;
         end else if (busy && isa_ack) begin
            busy     <= 1'b0;
            isa_rd   <= 1'b0;
            isa_wr   <= 1'b0;
            cpu_done <= 1'b1;
            if (isa_rd) begin
               cpu_rvalid <= 1'b1;
               cpu_rdata  <= rd_swapped;
            end
         end
      end
   end
endmodule

// File: rtl/isa_io_xlate.sv
`timescale 1ns/1ps
module isa_io_xlate #(
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int PORT_W      = 16,
   parameter int WIN_BITS    = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
   parameter int SPARSE_KEEP = 5,
   parameter int SPARSE_FROM = 12,
   parameter bit SWAP_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [1:0]        cpu_size,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_ready,
   output logic              cpu_done,
   output logic              cpu_rvalid,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              map_sparse,
   input  logic              big_endian,
   output logic [PORT_W-1:0] isa_port,
   output logic [1:0]        isa_size,
   output logic [DATA_W-1:0] isa_wdata,
   output logic              isa_rd,
   output logic              isa_wr,
   input  logic              isa_ack,
   input  logic [DATA_W-1:0] isa_rdata
);
   logic              hit;
   logic              busy;
   logic              be_q;
   logic [PORT_W-1:0] port_next;
   logic [DATA_W-1:0] wdata_swapped;
   logic [DATA_W-1:0] rdata_swapped;

   isa_addr_remap #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_BITS(WIN_BITS),
      .WIN_BASE(WIN_BASE), .SPARSE_KEEP(SPARSE_KEEP), .SPARSE_FROM(SPARSE_FROM)
   ) u_remap (
      .addr(cpu_addr), .sparse(map_sparse), .hit(hit), .port(port_next)
   );

   isa_lane_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_wswap (
      .din(cpu_wdata), .size(cpu_size), .be(big_endian), .dout(wdata_swapped)
   );

   isa_lane_swap #(.DATA_W(DATA_W), .SWAP_EN(SWAP_EN)) u_rswap (
      .din(isa_rdata), .size(isa_size), .be(be_q), .dout(rdata_swapped)
   );

   isa_xlate_ctrl #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .start(cpu_req && hit), .start_we(cpu_we), .start_size(cpu_size),
      .start_port(port_next), .start_wdata(wdata_swapped), .start_be(big_endian),
      .isa_ack(isa_ack), .rd_swapped(rdata_swapped),
      .busy(busy), .be_q(be_q),
      .isa_rd(isa_rd), .isa_wr(isa_wr), .isa_port(isa_port), .isa_size(isa_size),
      .isa_wdata(isa_wdata), .cpu_done(cpu_done), .cpu_rvalid(cpu_rvalid),
      .cpu_rdata(cpu_rdata)
   );

   assign cpu_ready = !busy;
endmodule

// File: rtl/isa_xlate_checker.sv
`timescale 1ns/1ps
module isa_xlate_checker #(
   parameter int ADDR_W   = 32,
   parameter int PORT_W   = 16,
   parameter int WIN_BITS = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              cpu_done,
   input logic              cpu_rvalid,
   input logic [PORT_W-1:0] isa_port,
   input logic              isa_rd,
   input logic              isa_wr,
   input logic              isa_ack
);
   logic in_win;
   logic strobe;
   assign in_win = (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
   assign strobe = isa_rd || isa_wr;

   assert_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && in_win |=> strobe);
   assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && cpu_ready && !in_win |=> !strobe && !cpu_done);
   assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(isa_rd && isa_wr));
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && !isa_ack |=> strobe && $stable(isa_port));
   assert_finish_R10: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && isa_ack |=> cpu_done && !strobe);
   assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> cpu_done);
   assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |-> !cpu_ready);
endmodule

bind isa_io_xlate isa_xlate_checker #(
   .ADDR_W(ADDR_W), .PORT_W(PORT_W), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rvalid(cpu_rvalid),
   .isa_port(isa_port), .isa_rd(isa_rd), .isa_wr(isa_wr), .isa_ack(isa_ack)
);

// File: tb/isa_io_xlate_bench.sv
`timescale 1ns/1ps
module isa_io_xlate_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [1:0]  cpu_size = '0;
   logic        cpu_ready, cpu_done, cpu_rvalid;
   logic [31:0] cpu_rdata;
   logic        map_sparse = 1'b0, big_endian = 1'b0;
   logic [15:0] isa_port;
   logic [1:0]  isa_size;
   logic [31:0] isa_wdata;
   logic        isa_rd, isa_wr;
   logic        isa_ack = 1'b0;
   logic [31:0] isa_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   isa_io_xlate u_isa_io_xlate (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rvalid(cpu_rvalid),
      .cpu_rdata(cpu_rdata), .map_sparse(map_sparse), .big_endian(big_endian),
      .isa_port(isa_port), .isa_size(isa_size), .isa_wdata(isa_wdata),
      .isa_rd(isa_rd), .isa_wr(isa_wr), .isa_ack(isa_ack), .isa_rdata(isa_rdata)
   );

   function automatic logic [15:0] exp_port(logic [31:0] a, logic sp);
      return sp ? {a[22:12], a[4:0]} : a[15:0];
   endfunction

   function automatic logic [31:0] exp_swap(logic [31:0] d, logic [1:0] sz, logic be);
      if (!be || sz == 2'd0) return d;
      if (sz == 2'd1) return {d[31:16], d[7:0], d[15:8]};
      return {d[7:0], d[15:8], d[23:16], d[31:24]};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // One full access; delay = wait cycles before the acknowledge.
   task automatic access(logic [31:0] a, logic we, logic [1:0] sz, logic [31:0] wd,
                         logic sp, logic be, int delay, logic [31:0] rd);
      @(negedge clk);
      cpu_req = 1; cpu_addr = a; cpu_we = we; cpu_size = sz; cpu_wdata = wd;
      map_sparse = sp; big_endian = be;
      @(negedge clk);
      cpu_req = 0;
      check("R9 read strobe", {31'd0, isa_rd}, {31'd0, !we});
      check("R9 write strobe", {31'd0, isa_wr}, {31'd0, we});
      check(sp ? "R3 sparse port" : "R2 flat port", {16'd0, isa_port}, {16'd0, exp_port(a, sp)});
      check("R9 size copy", {30'd0, isa_size}, {30'd0, sz});
      if (we) check(sz == 0 ? "R5 byte wdata" : (!be ? "R8 le wdata" :
                    (sz == 1 ? "R6 half wdata" : "R7 word wdata")),
                    isa_wdata, exp_swap(wd, sz, be));
      check("R11 ready low", {31'd0, cpu_ready}, 32'd0);
      // R4: flip selects while busy; R11: present a competing request.
      map_sparse = !sp; big_endian = !be;
      if (delay > 0) begin
         cpu_req = 1; cpu_addr = a ^ 32'h0000_0FE0; cpu_we = !we;
      end
      for (int i = 0; i < delay; i++) begin
         @(negedge clk);
         check("R9 strobe held", {31'd0, isa_rd | isa_wr}, 32'd1);
         check("R4 port stable", {16'd0, isa_port}, {16'd0, exp_port(a, sp)});
      end
      cpu_req = 0; isa_ack = 1; isa_rdata = rd;
      @(negedge clk);
      isa_ack = 0;
      check("R10 done pulse", {31'd0, cpu_done}, 32'd1);
      check("R10 rvalid", {31'd0, cpu_rvalid}, {31'd0, !we});
      check("R10 strobes low", {30'd0, isa_rd, isa_wr}, 32'd0);
      if (!we) check(be ? "R4 R6 R7 read swap" : "R8 le read", cpu_rdata, exp_swap(rd, sz, be));
      @(negedge clk);
      check("R10 done one cycle", {31'd0, cpu_done}, 32'd0);
      check("R11 busy request ignored", {30'd0, isa_rd, isa_wr}, 32'd0);
   endtask

   task automatic outside(logic [31:0] a);
      @(negedge clk);
      cpu_req = 1; cpu_addr = a; cpu_we = 1;
      @(negedge clk);
      cpu_req = 0;
      check("R1 outside no strobe", {30'd0, isa_rd, isa_wr}, 32'd0);
      check("R1 outside ready", {31'd0, cpu_ready}, 32'd1);
      check("R1 outside no done", {31'd0, cpu_done}, 32'd0);
   endtask

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R12 reset strobes", {30'd0, isa_rd, isa_wr}, 32'd0);
      check("R12 reset ready", {31'd0, cpu_ready}, 32'd1);
      check("R12 reset done", {30'd0, cpu_done, cpu_rvalid}, 32'd0);
      rst_n = 1;

      // Directed corners
      access(32'h8012_3456, 1, 2'd0, 32'hA1B2_C3D4, 0, 1, 0, 32'h0);     // R5 byte BE
      access(32'h807F_F03F, 1, 2'd1, 32'h1122_3344, 1, 1, 2, 32'h0);     // R3 R6
      access(32'h8000_0FE0, 0, 2'd2, 32'h0, 1, 1, 1, 32'hDEAD_BEEF);     // R3 bits 11..5 dropped, R7
      access(32'h8055_AA55, 0, 2'd3, 32'h0, 0, 1, 3, 32'h0102_0304);     // R7 reserved
      access(32'h8000_1234, 0, 2'd1, 32'h0, 0, 0, 0, 32'h5566_7788);     // R8
      access(32'h8000_1234, 0, 2'd1, 32'h0, 0, 1, 0, 32'h5566_7788);     // R6 read
      outside(32'h7FFF_FFFF);
      outside(32'h8080_0000);
      outside(32'h0000_0000);

      // Back-to-back: completion pulse with a waiting request.
      @(negedge clk);
      cpu_req = 1; cpu_addr = 32'h8000_0100; cpu_we = 0; cpu_size = 0;
      map_sparse = 0; big_endian = 0;
      @(negedge clk);
      cpu_req = 0; isa_ack = 1; isa_rdata = 32'h77;
      @(negedge clk);
      isa_ack = 0;
      check("R10 b2b done", {31'd0, cpu_done}, 32'd1);
      check("R11 b2b ready", {31'd0, cpu_ready}, 32'd1);
      cpu_req = 1; cpu_addr = 32'h8000_0200; cpu_we = 1;
      @(negedge clk);
      cpu_req = 0;
      check("R10 b2b done fell", {31'd0, cpu_done}, 32'd0);
      check("R9 b2b write strobe", {31'd0, isa_wr}, 32'd1);
      check("R2 b2b port", {16'd0, isa_port}, 32'h0000_0200);
      isa_ack = 1;
      @(negedge clk);
      isa_ack = 0;
      check("R10 b2b second done", {31'd0, cpu_done}, 32'd1);

      // Constrained random
      for (int n = 0; n < 40; n++) begin
         access(32'h8000_0000 | ($urandom & 32'h007F_FFFF), 1'($urandom),
                2'($urandom), $urandom, 1'($urandom), 1'($urandom),
                int'($urandom % 4), $urandom);
      end
      finish_run();
   end
endmodule